// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recent virtual-to-physical page mappings for 4 KB pages. Every lookup compares the virtual page number of the request against all resident mappings in parallel. On a match it returns, in the same cycle, a physical address made of the stored physical page number and the untouched 12-bit page offset. When nothing matches it raises a miss flag combinationally, so the surrounding pipeline can stop the faulting access before any register is written. An external handler then loads the missing mapping through a refill port.

Each mapping carries a reference bit and a dirty bit. A hit sets the reference bit, and a write hit also sets the dirty bit. The lookup reports both bits as they stood before the access. Refills take a free slot first and otherwise evict the least recently used mapping. A clear-reference strobe and a flush strobe act on all entries at once.

Top module: `fa_tlb`

## Requirements
- R1: A lookup whose virtual page number matches a valid entry asserts `lk_hit_o` in the same cycle, and `lk_paddr_o` equals the stored physical page number above bits [11:0] of `lk_vaddr_i`.
- R2: A lookup (`lk_valid_i`=1) with no matching valid entry asserts `lk_miss_o` and deasserts `lk_hit_o` in that same cycle. With `lk_valid_i`=0 both flags are 0.
- R3: A hit sets the entry's reference bit. `lk_ref_o` shows the bit as it was before the access.
- R4: A write hit (`lk_write_i`=1) sets the entry's dirty bit. A read hit leaves it unchanged. `lk_dirty_o` shows the bit as it was before the access.
- R5: A refill installs the mapping as valid with reference and dirty bits at 0, and the mapping hits from the next cycle on.
- R6: A refill selects the lowest-numbered invalid entry whenever one exists, so N refills after a reset or flush leave N resident mappings.
- R7: When every entry is valid, a refill evicts the entry least recently used. Both hits and refills count as uses.
- R8: A refill in the same cycle as a lookup takes priority. The lookup reports a miss and updates no status bit.
- R9: A one-cycle `clr_ref_i` pulse clears every reference bit and leaves dirty bits unchanged.
- R10: `flush_i` invalidates every entry in one cycle. A lookup or refill in the same cycle is dropped, and the lookup reports a miss.
- R11: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_write_i | input | 1 | Lookup is a store (sets dirty on hit) |
| lk_vaddr_i | input | VA_W | Virtual address to translate |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | Lookup requested but no translation |
| lk_paddr_o | output | PA_W | Physical address on hit, zero otherwise |
| lk_ref_o | output | 1 | Reference bit of the hit entry before the access |
| lk_dirty_o | output | 1 | Dirty bit of the hit entry before the access |
| fill_en_i | input | 1 | Refill strobe |
| fill_vpn_i | input | VA_W-12 | Virtual page number to install |
| fill_ppn_i | input | PA_W-12 | Physical page number to install |
| clr_ref_i | input | 1 | Clear all reference bits |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The single-match check assumes the refill handler never installs a virtual page number that is already resident. The bench meets this by refilling only after a miss on that page, or after a flush. The fill-freshness and status-bit properties only relate a cycle to the next one when the address is held steady, so they do not depend on the order of requests. The stimulus applies every input change at the falling edge, so nothing changes while the design samples its inputs.

// File: rtl/fa_tlb_pkg.sv
`timescale 1ns/1ps
package fa_tlb_pkg;
    // Page offset width for 4 KB pages; these bits bypass translation.
    localparam int PG_OFS_W = 12;
endpackage

// File: rtl/fa_tlb_match.sv
`timescale 1ns/1ps
// Parallel tag comparison across all entries with index encoding.
module fa_tlb_match #(
    parameter int N     = 48,
    parameter int VPN_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              vld_i,
    input  logic [N-1:0][VPN_W-1:0]   tag_i,
    input  logic [VPN_W-1:0]          q_vpn_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld_i[g] && (tag_i[g] == q_vpn_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match;

    // R2: a page number is resident in at most one entry
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/fa_tlb_victim.sv
`timescale 1ns/1ps
// Refill slot choice: lowest free slot, else the oldest by age rank.
module fa_tlb_victim #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              vld_i,
    input  logic [N-1:0][IDX_W-1:0]   age_i,
    output logic [IDX_W-1:0]          victim_o
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

    logic [N-1:0] oldest;

    for (genvar g = 0; g < N; g++) begin : g_old
        assign oldest[g] = (age_i[g] == OLDEST);
    end

    always_comb begin
        victim_o = '0;
        if (&vld_i) begin
            for (int i = 0; i < N; i++) begin
                if (oldest[i]) victim_o = IDX_W'(i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!vld_i[i]) victim_o = IDX_W'(i);
            end
        end
    end

    // R7: age ranks stay a permutation, exactly one entry is oldest
    lru_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest));

    // R6: a valid entry is chosen only when no free slot exists
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i[victim_o] || (&vld_i));
endmodule

// File: rtl/fa_tlb.sv
`timescale 1ns/1ps
module fa_tlb
    import fa_tlb_pkg::*;
#(
    parameter int N    = 48,
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid_i,
    input  logic                    lk_write_i,
    input  logic [VA_W-1:0]         lk_vaddr_i,
    output logic                    lk_hit_o,
    output logic                    lk_miss_o,
    output logic [PA_W-1:0]         lk_paddr_o,
    output logic                    lk_ref_o,
    output logic                    lk_dirty_o,
    input  logic                    fill_en_i,
    input  logic [VA_W-PG_OFS_W-1:0] fill_vpn_i,
    input  logic [PA_W-PG_OFS_W-1:0] fill_ppn_i,
    input  logic                    clr_ref_i,
    input  logic                    flush_i
);
    localparam int VPN_W = VA_W - PG_OFS_W;
    localparam int PPN_W = PA_W - PG_OFS_W;
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [N-1:0]              vld;
        logic [N-1:0]              rf;
        logic [N-1:0]              dty;
        logic [N-1:0][VPN_W-1:0]   vpn;
        logic [N-1:0][PPN_W-1:0]   ppn;
        logic [N-1:0][IDX_W-1:0]   age;
    } tlb_st_t;

    tlb_st_t st_d, st_q;

    logic             hit_raw, hit_eff, touch_en;
    logic [IDX_W-1:0] hit_idx, vic_idx, touch_idx;
    logic [IDX_W-1:0] touch_age;

    function automatic tlb_st_t reset_state();
        tlb_st_t s;
        s = '0;
        for (int i = 0; i < N; i++) s.age[i] = IDX_W'(i);
        return s;
    endfunction

    fa_tlb_match #(.N(N), .VPN_W(VPN_W), .IDX_W(IDX_W)) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (st_q.vld),
        .tag_i   (st_q.vpn),
        .q_vpn_i (lk_vaddr_i[VA_W-1:PG_OFS_W]),
        .hit_o   (hit_raw),
        .idx_o   (hit_idx)
    );

    fa_tlb_victim #(.N(N), .IDX_W(IDX_W)) victim_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (st_q.vld),
        .age_i    (st_q.age),
        .victim_o (vic_idx)
    );

    // Lookup results, valid in the request cycle.
    assign hit_eff    = lk_valid_i && hit_raw && !fill_en_i && !flush_i;
    assign lk_hit_o   = hit_eff;
    assign lk_miss_o  = lk_valid_i && !hit_eff;
    assign lk_paddr_o = hit_eff ? {st_q.ppn[hit_idx], lk_vaddr_i[PG_OFS_W-1:0]} : '0;
    assign lk_ref_o   = hit_eff && st_q.rf[hit_idx];
    assign lk_dirty_o = hit_eff && st_q.dty[hit_idx];

    always_comb begin
        st_d      = st_q;
        touch_en  = 1'b0;
        touch_idx = '0;

        if (clr_ref_i) st_d.rf = '0;

        if (flush_i) begin
            st_d.vld = '0;
        end else if (fill_en_i) begin
            st_d.vld[vic_idx] = 1'b1;
            st_d.vpn[vic_idx] = fill_vpn_i;
            st_d.ppn[vic_idx] = fill_ppn_i;
            st_d.rf[vic_idx]  = 1'b0;
            st_d.dty[vic_idx] = 1'b0;
            touch_en  = 1'b1;
            touch_idx = vic_idx;
        end else if (hit_eff) begin
            st_d.rf[hit_idx] = 1'b1;
            if (lk_write_i) st_d.dty[hit_idx] = 1'b1;
            touch_en  = 1'b1;
            touch_idx = hit_idx;
        end

        // Recency update: used entry becomes youngest, younger ones age by one.
        touch_age = st_q.age[touch_idx];
        if (touch_en) begin
            for (int j = 0; j < N; j++) begin
                if (IDX_W'(j) == touch_idx)
                    st_d.age[j] = '0;
                else if (st_q.age[j] < touch_age)
                    st_d.age[j] = st_q.age[j] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> (lk_paddr_o[PG_OFS_W-1:0] == lk_vaddr_i[PG_OFS_W-1:0]));

    // R3
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |=> (!(lk_hit_o && $stable(lk_vaddr_i)) || lk_ref_o));

    // R4
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit_o && lk_write_i) |=> (!(lk_hit_o && $stable(lk_vaddr_i)) || lk_dirty_o));

    // R5
    fill_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en_i && !flush_i) |=>
        (!(lk_valid_i && !fill_en_i && !flush_i &&
           lk_vaddr_i[VA_W-1:PG_OFS_W] == $past(fill_vpn_i))
         || (lk_hit_o && !lk_ref_o && !lk_dirty_o)));

    // R9
    clr_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ref_i && !lk_hit_o) |=> !lk_ref_o);

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !lk_hit_o);
endmodule

// File: tb/fa_tlb_tb_top.sv
`timescale 1ns/1ps
module fa_tlb_tb_top;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_ref, lk_dirty;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        clr_ref = 1'b0, flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fa_tlb #(.N(N), .VA_W(32), .PA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid_i(lk_valid), .lk_write_i(lk_write), .lk_vaddr_i(lk_vaddr),
        .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_paddr_o(lk_paddr),
        .lk_ref_o(lk_ref), .lk_dirty_o(lk_dirty),
        .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
        .clr_ref_i(clr_ref), .flush_i(flush)
    );

    task automatic chk_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        lk_valid = 0; lk_write = 0; fill_en = 0; clr_ref = 0; flush = 0;
    endtask

    // Lookup with combinational result checked mid-cycle.
    task automatic look(input logic [31:0] va, input logic wr, input logic eh,
                        input logic [19:0] eppn, input logic er, input logic ed,
                        input string rq);
        @(negedge clk);
        lk_valid = 1; lk_write = wr; lk_vaddr = va; #1;
        chk_eq(rq, "hit", lk_hit, eh);
        chk_eq(rq, "miss", lk_miss, !eh);
        if (eh) begin
            chk_eq(rq, "paddr", lk_paddr, {eppn, va[11:0]});
            chk_eq(rq, "ref", lk_ref, er);
            chk_eq(rq, "dirty", lk_dirty, ed);
        end
        idle();
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p);
        @(negedge clk);
        fill_en = 1; fill_vpn = v; fill_ppn = p;
        idle();
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_ref = 1; idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        lk_valid = 1; lk_vaddr = 32'h0000_0abc; #1;
        chk_eq("R11", "hit in reset", lk_hit, 0);
        @(negedge clk); rst_n = 1;
        lk_valid = 0; #1;
        chk_eq("R2", "idle miss", lk_miss, 0);
        look(32'h0000_0abc, 0, 0, '0, 0, 0, "R11");
    endtask

    task automatic t_basic();
        fill(20'h12345, 20'habcde);
        look(32'h1234_5678, 0, 1, 20'habcde, 0, 0, "R5");
        look(32'h1234_5fff, 0, 1, 20'habcde, 1, 0, "R1");
        look(32'h1234_5000, 1, 1, 20'habcde, 1, 0, "R3");
        look(32'h1234_5010, 0, 1, 20'habcde, 1, 1, "R4");
        look(32'h1234_4678, 0, 0, '0, 0, 0, "R2");
        look(32'h9234_5678, 0, 0, '0, 0, 0, "R2");
    endtask

    task automatic t_clr();
        pulse_clr();
        look(32'h1234_5001, 0, 1, 20'habcde, 0, 1, "R9");
    endtask

    task automatic t_fill_prio();
        pulse_clr();
        @(negedge clk);
        fill_en = 1; fill_vpn = 20'h00777; fill_ppn = 20'h55555;
        lk_valid = 1; lk_write = 1; lk_vaddr = 32'h1234_5002; #1;
        chk_eq("R8", "hit under fill", lk_hit, 0);
        chk_eq("R8", "miss under fill", lk_miss, 1);
        idle();
        look(32'h1234_5003, 0, 1, 20'habcde, 0, 1, "R8");
        look(32'h0077_7123, 0, 1, 20'h55555, 0, 0, "R5");
    endtask

    task automatic t_flush();
        @(negedge clk); flush = 1; idle();
        look(32'h1234_5004, 0, 0, '0, 0, 0, "R10");
        look(32'h0077_7123, 0, 0, '0, 0, 0, "R10");
        @(negedge clk);
        flush = 1; fill_en = 1; fill_vpn = 20'h00abc; fill_ppn = 20'h00001;
        lk_valid = 1; lk_vaddr = 32'h1234_5004; #1;
        chk_eq("R10", "hit during flush", lk_hit, 0);
        idle();
        look(32'h00ab_c000, 0, 0, '0, 0, 0, "R10");
    endtask

    task automatic t_lru();
        for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h00800 + 20'(i));
        for (int i = 0; i < N; i++)
            look({20'h00100 + 20'(i), 12'h044}, 0, 1, 20'h00800 + 20'(i), 0, 0, "R6");
        look({20'h00100, 12'h0}, 0, 1, 20'h00800, 1, 0, "R7");
        fill(20'h00900, 20'h00f00);
        look({20'h00101, 12'h0}, 0, 0, '0, 0, 0, "R7");
        look({20'h00100, 12'h0}, 0, 1, 20'h00800, 1, 0, "R7");
        look({20'h00900, 12'h0}, 0, 1, 20'h00f00, 0, 0, "R7");
        look({20'h00102, 12'h0}, 0, 1, 20'h00802, 1, 0, "R7");
        fill(20'h00901, 20'h00f01);
        look({20'h00103, 12'h0}, 0, 0, '0, 0, 0, "R7");
        look({20'h00901, 12'h0}, 0, 1, 20'h00f01, 0, 0, "R7");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_basic();
        t_clr();
        t_fill_prio();
        t_flush();
        t_lru();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule